// File: doc/BRIEF.md
# Hardwired Step-Sequenced Control Unit

This block is the controller for a single-bus processor datapath. A step counter steps through time slots T1 to Tn, and a one-hot step decoder presents the current slot. An opcode decoder produces one active instruction line. Each datapath control strobe is an OR of products, where each product pairs a time slot with an instruction line. Some products also include the negative flag.

Every instruction starts with three fetch slots. T1 puts the program counter on the bus, loads the address register, starts a read and forms the incremented counter in Z. T2 writes Z back into the program counter and waits for memory. T3 moves the data register into the instruction register. The opcode then selects the rest of the sequence:
- an add of a memory operand, addressed through a pointer register, into a destination register;
- a PC-relative jump;
- a jump taken only when the negative flag is set.

The counter advances only while the step is not waiting on memory. It returns to T1 on the end strobe or on reset.

Top module: `hw_step_ctrl`

## Requirements
- R1: Exactly one bit of `t_slot` is high at all times. Bit k stands for slot T(k+1). A high `rst` at a clock edge makes T1 the slot from that edge onward, from any slot.
- R2: When `wait_mfc` is low and `end_step` is low, the slot moves from Tk to Tk+1 at each clock edge. When `end_step` is high, the next slot is T1.
- R3: While `wait_mfc` is high and `mem_done` is low, the slot and all control outputs hold. With `mem_done` high, the wait slot advances at the next edge.
- R4: Fetch outputs are the same for every opcode:
  - T1 asserts `pc_out`, `mar_in`, `mem_read`, `carry_set`, `alu_add` and `z_in`.
  - T2 asserts `z_out`, `pc_in` and `wait_mfc`.
  - T3 asserts `mdr_out` and `ir_in`.
- R5: Opcode 1 is the indirect add. Its slots are:
  - T4: `ptr_out`, `mar_in`, `mem_read`.
  - T5: `dst_out`, `y_in`, `wait_mfc`.
  - T6: `mdr_out`, `alu_add`, `z_in`.
  - T7: `z_out`, `dst_in`, `end_step`.
  `neg_flag` has no effect on this sequence.
- R6: Opcode 2 is the unconditional jump. Its slots are:
  - T4: `pc_out`, `y_in`.
  - T5: `off_out`, `alu_add`, `z_in`.
  - T6: `z_out`, `pc_in`, `end_step`.
  `neg_flag` has no effect on this sequence.
- R7: Opcode 3 is the jump-if-negative. With `neg_flag` high it follows R6 exactly. With `neg_flag` low, T4 asserts `pc_out`, `y_in` and `end_step`, and the next slot is T1.
- R8: Any other opcode asserts only `end_step` in T4, and then returns to T1.
- R9: In any slot, at most one of `pc_out`, `z_out`, `mdr_out`, `ptr_out`, `dst_out` and `off_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset to slot T1 |
| op_code | input | OPC_W | Opcode field of the instruction register |
| neg_flag | input | 1 | Negative status flag |
| mem_done | input | 1 | Memory function complete |
| t_slot | output | STEPS | One-hot current time slot |
| pc_out | output | 1 | Program counter drives the bus |
| pc_in | output | 1 | Program counter loads from the bus |
| mar_in | output | 1 | Address register loads from the bus |
| mem_read | output | 1 | Start a memory read |
| carry_set | output | 1 | Force ALU carry-in |
| alu_add | output | 1 | ALU function is add |
| z_in | output | 1 | Z loads the ALU result |
| z_out | output | 1 | Z drives the bus |
| mdr_out | output | 1 | Data register drives the bus |
| ir_in | output | 1 | Instruction register loads from the bus |
| y_in | output | 1 | Y loads from the bus |
| ptr_out | output | 1 | Pointer register drives the bus |
| dst_out | output | 1 | Destination register drives the bus |
| dst_in | output | 1 | Destination register loads from the bus |
| off_out | output | 1 | Offset field of the instruction drives the bus |
| wait_mfc | output | 1 | Step waits for memory completion |
| end_step | output | 1 | Last step of the instruction |

## Verification
The bench uses the default parameters. These are a 4-bit opcode, eight time slots and opcodes 1, 2 and 3 for add, jump and jump-if-negative. With eight slots the longest sequence, the add ending in T7, fits with one spare slot. Opcode 7 reaches the undefined-opcode path, and both values of the negative flag reach both exits of the conditional jump. Memory completion is held low in both wait slots (T2 and T5 of the add) to exercise the stall.

// File: rtl/hw_step_ctrl.sv
module hw_step_ctrl #(
  parameter int OPC_W = 4,
  parameter int STEPS = 8,
  parameter logic [OPC_W-1:0] OP_ADD = 1,
  parameter logic [OPC_W-1:0] OP_BR  = 2,
  parameter logic [OPC_W-1:0] OP_BRN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] op_code,
  input  logic             neg_flag,
  input  logic             mem_done,
  output logic [STEPS-1:0] t_slot,
  output logic             pc_out,
  output logic             pc_in,
  output logic             mar_in,
  output logic             mem_read,
  output logic             carry_set,
  output logic             alu_add,
  output logic             z_in,
  output logic             z_out,
  output logic             mdr_out,
  output logic             ir_in,
  output logic             y_in,
  output logic             ptr_out,
  output logic             dst_out,
  output logic             dst_in,
  output logic             off_out,
  output logic             wait_mfc,
  output logic             end_step
);
  // STEPS must be at least 7 for the add sequence
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [CW-1:0] step_q;
  logic run;
  logic t1, t2, t3, t4, t5, t6, t7;
  logic i_add, i_br, i_brn, i_und, br_any;

  assign run = !(wait_mfc && !mem_done);

  always_ff @(posedge clk) begin
    if (rst)
      step_q <= '0;
    else if (run) begin
      if (end_step || step_q == CW'(STEPS-1))
        step_q <= '0;
      else
        step_q <= step_q + 1'b1;
    end
  end

  for (genvar g = 0; g < STEPS; g++) begin : g_slot
    assign t_slot[g] = (step_q == CW'(g));
  end

  assign t1 = t_slot[0];
  assign t2 = t_slot[1];
  assign t3 = t_slot[2];
  assign t4 = t_slot[3];
  assign t5 = t_slot[4];
  assign t6 = t_slot[5];
  assign t7 = t_slot[6];

  assign i_add  = (op_code == OP_ADD);
  assign i_br   = (op_code == OP_BR);
  assign i_brn  = (op_code == OP_BRN);
  assign i_und  = !(i_add || i_br || i_brn);
  assign br_any = i_br || i_brn;

  assign pc_out    = t1 | (t4 & br_any);
  assign pc_in     = t2 | (t6 & br_any);
  assign mar_in    = t1 | (t4 & i_add);
  assign mem_read  = t1 | (t4 & i_add);
  assign carry_set = t1;
  assign alu_add   = t1 | (t6 & i_add) | (t5 & br_any);
  assign z_in      = t1 | (t6 & i_add) | (t5 & br_any);
  assign z_out     = t2 | (t7 & i_add) | (t6 & br_any);
  assign mdr_out   = t3 | (t6 & i_add);
  assign ir_in     = t3;
  assign y_in      = (t5 & i_add) | (t4 & br_any);
  assign ptr_out   = t4 & i_add;
  assign dst_out   = t5 & i_add;
  assign dst_in    = t7 & i_add;
  assign off_out   = t5 & br_any;
  assign wait_mfc  = t2 | (t5 & i_add);
  assign end_step  = (t7 & i_add) | (t6 & i_br)
                   | (((t6 & neg_flag) | (t4 & !neg_flag)) & i_brn)
                   | (t4 & i_und);

  p_reset_t1_r1: assert property (@(posedge clk) rst |=> t_slot[0]);

  p_slot_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot(t_slot));

  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (!wait_mfc && !end_step && !t_slot[STEPS-1]) |=> (t_slot == ($past(t_slot) << 1)));

  p_end_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    end_step |=> t_slot[0]);

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (wait_mfc && !mem_done) |=> $stable(t_slot));

  p_one_driver_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_out, z_out, mdr_out, ptr_out, dst_out, off_out}));
endmodule

// File: tb/hw_step_ctrl_test.sv
module hw_step_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] op_code = 4'd0;
  logic neg_flag = 1'b0;
  logic mem_done = 1'b0;
  logic [7:0] t_slot;
  logic pc_out, pc_in, mar_in, mem_read, carry_set, alu_add, z_in, z_out;
  logic mdr_out, ir_in, y_in, ptr_out, dst_out, dst_in, off_out, wait_mfc, end_step;
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  hw_step_ctrl uut (
    .clk(clk), .rst(rst), .op_code(op_code), .neg_flag(neg_flag), .mem_done(mem_done),
    .t_slot(t_slot), .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in), .mem_read(mem_read),
    .carry_set(carry_set), .alu_add(alu_add), .z_in(z_in), .z_out(z_out), .mdr_out(mdr_out),
    .ir_in(ir_in), .y_in(y_in), .ptr_out(ptr_out), .dst_out(dst_out), .dst_in(dst_in),
    .off_out(off_out), .wait_mfc(wait_mfc), .end_step(end_step)
  );

  logic [16:0] ctl;
  assign ctl = {pc_out, pc_in, mar_in, mem_read, carry_set, alu_add, z_in, z_out,
                mdr_out, ir_in, y_in, ptr_out, dst_out, dst_in, off_out, wait_mfc, end_step};

  localparam logic [16:0] PCO = 17'h10000, PCI = 17'h08000, MARI = 17'h04000, RD = 17'h02000;
  localparam logic [16:0] CIN = 17'h01000, ADDF = 17'h00800, ZI = 17'h00400, ZO = 17'h00200;
  localparam logic [16:0] MDRO = 17'h00100, IRI = 17'h00080, YI = 17'h00040, PTRO = 17'h00020;
  localparam logic [16:0] DSTO = 17'h00010, DSTI = 17'h00008, OFFO = 17'h00004, WT = 17'h00002;
  localparam logic [16:0] EN = 17'h00001;
  localparam logic [16:0] F1 = PCO | MARI | RD | CIN | ADDF | ZI;
  localparam logic [16:0] F2 = ZO | PCI | WT;
  localparam logic [16:0] F3 = MDRO | IRI;

  // {req, op, n, mfc, slot, ctl}
  localparam int NV = 37;
  localparam logic [30:0] VEC [0:NV-1] = '{
    {4'd4, 4'd1, 1'b0, 1'b0, 4'd1, F1},              // R4 fetch
    {4'd3, 4'd1, 1'b0, 1'b0, 4'd2, F2},              // R3 stall
    {4'd3, 4'd1, 1'b0, 1'b1, 4'd2, F2},              // R3 still T2
    {4'd4, 4'd1, 1'b0, 1'b0, 4'd3, F3},
    {4'd5, 4'd1, 1'b1, 1'b0, 4'd4, PTRO | MARI | RD}, // R5, N ignored
    {4'd5, 4'd1, 1'b1, 1'b1, 4'd5, DSTO | YI | WT},
    {4'd5, 4'd1, 1'b0, 1'b0, 4'd6, MDRO | ADDF | ZI},
    {4'd5, 4'd1, 1'b1, 1'b0, 4'd7, ZO | DSTI | EN},
    {4'd2, 4'd2, 1'b0, 1'b0, 4'd1, F1},              // R2 end wraps
    {4'd4, 4'd2, 1'b0, 1'b1, 4'd2, F2},
    {4'd4, 4'd2, 1'b0, 1'b0, 4'd3, F3},
    {4'd6, 4'd2, 1'b0, 1'b0, 4'd4, PCO | YI},        // R6
    {4'd6, 4'd2, 1'b1, 1'b0, 4'd5, OFFO | ADDF | ZI},
    {4'd6, 4'd2, 1'b0, 1'b0, 4'd6, ZO | PCI | EN},
    {4'd4, 4'd3, 1'b1, 1'b0, 4'd1, F1},
    {4'd4, 4'd3, 1'b1, 1'b1, 4'd2, F2},
    {4'd4, 4'd3, 1'b1, 1'b0, 4'd3, F3},
    {4'd7, 4'd3, 1'b1, 1'b0, 4'd4, PCO | YI},        // R7 taken
    {4'd7, 4'd3, 1'b1, 1'b0, 4'd5, OFFO | ADDF | ZI},
    {4'd7, 4'd3, 1'b1, 1'b0, 4'd6, ZO | PCI | EN},
    {4'd4, 4'd3, 1'b0, 1'b0, 4'd1, F1},
    {4'd4, 4'd3, 1'b0, 1'b1, 4'd2, F2},
    {4'd4, 4'd3, 1'b0, 1'b0, 4'd3, F3},
    {4'd7, 4'd3, 1'b0, 1'b0, 4'd4, PCO | YI | EN},   // R7 not taken
    {4'd7, 4'd7, 1'b0, 1'b0, 4'd1, F1},
    {4'd4, 4'd7, 1'b0, 1'b1, 4'd2, F2},
    {4'd4, 4'd7, 1'b0, 1'b0, 4'd3, F3},
    {4'd8, 4'd7, 1'b1, 1'b0, 4'd4, EN},              // R8 undefined
    {4'd8, 4'd1, 1'b0, 1'b0, 4'd1, F1},
    {4'd4, 4'd1, 1'b0, 1'b1, 4'd2, F2},
    {4'd4, 4'd1, 1'b0, 1'b0, 4'd3, F3},
    {4'd5, 4'd1, 1'b0, 1'b0, 4'd4, PTRO | MARI | RD},
    {4'd3, 4'd1, 1'b0, 1'b0, 4'd5, DSTO | YI | WT},  // R3 operand wait
    {4'd3, 4'd1, 1'b0, 1'b1, 4'd5, DSTO | YI | WT},
    {4'd5, 4'd1, 1'b0, 1'b0, 4'd6, MDRO | ADDF | ZI},
    {4'd5, 4'd1, 1'b0, 1'b0, 4'd7, ZO | DSTI | EN},
    {4'd2, 4'd1, 1'b0, 1'b0, 4'd1, F1}
  };

  task automatic chk(input int req, input logic [16:0] act, input logic [16:0] exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    #150000;
    n_fail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, {9'd0, t_slot}, 17'd1, "slot in reset");
    chk(4, ctl, F1, "outputs in reset");
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      op_code  = VEC[i][26:23];
      neg_flag = VEC[i][22];
      mem_done = VEC[i][21];
      #1;
      chk(int'(VEC[i][30:27]), {9'd0, t_slot}, 17'(1 << (VEC[i][20:17] - 1)), "slot");
      chk(int'(VEC[i][30:27]), ctl, VEC[i][16:0], "controls");
      @(posedge clk);
      @(negedge clk);
    end
    // R3 long stall in T2
    op_code = 4'd2; mem_done = 1'b0;
    @(negedge clk);
    repeat (50) @(negedge clk);
    chk(3, {9'd0, t_slot}, 17'd2, "slot after long stall");
    chk(3, ctl, F2, "controls after long stall");
    mem_done = 1'b1;
    @(negedge clk);
    mem_done = 1'b0;
    chk(3, {9'd0, t_slot}, 17'd4, "slot after completion");
    @(negedge clk);
    // R1 reset mid-instruction from T4
    chk(6, {9'd0, t_slot}, 17'd8, "slot before reset");
    rst = 1'b1;
    @(negedge clk);
    chk(1, {9'd0, t_slot}, 17'd1, "slot after mid reset");
    rst = 1'b0;
    @(negedge clk);
    chk(2, {9'd0, t_slot}, 17'd2, "advance after reset");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule